// File: doc/BRIEF.md
# Selectable Read Output Pipeline

This block is the last stage of the read path in a synchronous burst SRAM. It receives one command per clock from the input registers (read, deselect or no-op), together with the data the array returns for that read. From these it produces the data bus value and the enable of the tri-state bus drivers. An active-low output enable and a sleep input gate those drivers.

Two static strap inputs are captured while reset is held. The first selects either a flow-through output, with read latency 0, or a registered output, with read latency 1. The second selects how late a deselect takes effect. With single-cycle deselect the bus floats in the command's own cycle. With dual-cycle deselect it floats one cycle later. The four strap combinations therefore give four distinct timing relations between reads and deselects.

Outside the command effects, the bus holds its last state and value. When the effects of two commands fall due in the same cycle, the newer command decides the outcome.

Top module: `sro_read_out`

## Requirements
- R1: While reset is high, `dq_oe_o` is 0 and `dq_o` is 0. The strap inputs `pipe_sel_i` and `dcd_sel_i` are captured during reset and hold for the rest of operation.
- R2: `cmd_i` uses this encoding: 2'b01 is a read, 2'b10 is a deselect, and 2'b00 and 2'b11 are no-ops. In a cycle with no command effect due, `dq_o` and the drive state keep their previous values.
- R3: With `pipe_sel` captured low, a read drives `dq_oe_o` high and places `rd_data_i` on `dq_o` in the same cycle as the read command.
- R4: With `pipe_sel` captured high, the read's data and drive-on appear in the cycle after the read command.
- R5: With `dcd_sel` captured low, a deselect floats the bus (`dq_oe_o` low) in the same cycle as the deselect command. `dq_o` keeps its value.
- R6: With `dcd_sel` captured high, a deselect floats the bus in the cycle after the deselect command.
- R7: When the effects of two commands fall in the same cycle, the later command wins. In pipelined single-cycle-deselect mode, a read followed by a deselect floats the bus, and the read's data is never shown. In flow-through dual-cycle-deselect mode, a deselect followed by a read drives the new read's data.
- R8: `oe_n_i` high forces `dq_oe_o` low at once, with no clock edge needed. Releasing it restores the drive state at once.
- R9: While `sleep_i` is high, `dq_oe_o` is low and commands are ignored, including any effect still pending from the cycle before. The held drive state and data are retained and reappear after wake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high; straps are captured while high |
| pipe_sel_i | input | 1 | Strap: 1 = registered output, 0 = flow-through |
| dcd_sel_i | input | 1 | Strap: 1 = dual-cycle deselect, 0 = single-cycle deselect |
| cmd_i | input | 2 | Registered command for this cycle |
| rd_data_i | input | DW | Array data for a read in this cycle |
| oe_n_i | input | 1 | Asynchronous output enable, active low |
| sleep_i | input | 1 | Sleep request, active high |
| dq_o | output | DW | Data toward the bus drivers |
| dq_oe_o | output | 1 | Bus driver enable, active high |

## Verification
The sharpest case is a cycle in which one command's delayed effect and a newer command's immediate effect fall due together. In pipelined mode with single-cycle deselect, a read followed at once by a deselect makes the registered read data and the same-cycle float meet. In flow-through mode with dual-cycle deselect, a deselect followed at once by a read makes the late float and the same-cycle read meet. The bench provokes both with back-to-back rows that are replayed under all four strap settings. It judges every cycle's enable and data against a newest-wins model built from the latency rules.

// File: rtl/sro_pkg.sv
`timescale 1ns/1ps
package sro_pkg;

    typedef enum logic [1:0] {
        CMD_NOP   = 2'b00,
        CMD_READ  = 2'b01,
        CMD_DESEL = 2'b10,
        CMD_RSVD  = 2'b11
    } cmd_e;

    // captured strap settings
    typedef struct packed {
        logic pipe;   // 1: registered read output
        logic dcd;    // 1: deselect delayed one stage
    } mode_t;

    // a command effect on the drive state
    typedef struct packed {
        logic hit;    // an effect is due
        logic on;     // 1: drive on (read), 0: float (deselect)
    } evt_t;

    // effect that lands in the command's own cycle
    function automatic evt_t early_evt(cmd_e c, mode_t m, logic slp);
        evt_t e;
        e.hit = !slp && (((c == CMD_READ) && !m.pipe) ||
                         ((c == CMD_DESEL) && !m.dcd));
        e.on  = (c == CMD_READ);
        return e;
    endfunction

    // effect that lands one cycle after the command
    function automatic evt_t late_evt(cmd_e c, mode_t m, logic slp);
        evt_t e;
        e.hit = !slp && (((c == CMD_READ) && m.pipe) ||
                         ((c == CMD_DESEL) && m.dcd));
        e.on  = (c == CMD_READ);
        return e;
    endfunction

endpackage

// File: rtl/sro_mode_latch.sv
`timescale 1ns/1ps
module sro_mode_latch
    import sro_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  pipe_sel_i,
    input  logic  dcd_sel_i,
    output mode_t mode_o
);
    mode_t mode_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q.pipe <= pipe_sel_i;
            mode_q.dcd  <= dcd_sel_i;
        end
    end

    assign mode_o = mode_q;
endmodule

// File: rtl/sro_late_stage.sv
`timescale 1ns/1ps
module sro_late_stage
    import sro_pkg::*;
#(
    parameter int DW = 36
) (
    input  logic          clk,
    input  logic          rst,
    input  evt_t          evt_i,
    input  logic [DW-1:0] data_i,
    output evt_t          evt_o,
    output logic [DW-1:0] data_o
);
    evt_t          evt_q;
    logic [DW-1:0] data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            evt_q  <= '0;
            data_q <= '0;
        end else begin
            evt_q <= evt_i;
            if (evt_i.hit && evt_i.on) begin
                data_q <= data_i;
            end
        end
    end

    assign evt_o  = evt_q;
    assign data_o = data_q;
endmodule

// File: rtl/sro_resolver.sv
`timescale 1ns/1ps
module sro_resolver
    import sro_pkg::*;
#(
    parameter int DW = 36
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sleep_i,
    input  evt_t          early_i,
    input  logic [DW-1:0] early_data_i,
    input  evt_t          late_i,
    input  logic [DW-1:0] late_data_i,
    output logic          drv_en_o,
    output logic [DW-1:0] drv_data_o
);
    logic          en_q, en_n;
    logic [DW-1:0] dat_q, dat_n;

    // newest command wins: the early effect belongs to this cycle's command
    always_comb begin
        en_n  = en_q;
        dat_n = dat_q;
        if (early_i.hit) begin
            en_n = early_i.on;
            if (early_i.on) dat_n = early_data_i;
        end else if (late_i.hit) begin
            en_n = late_i.on;
            if (late_i.on) dat_n = late_data_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= 1'b0;
            dat_q <= '0;
        end else if (!sleep_i) begin
            en_q  <= en_n;
            dat_q <= dat_n;
        end
    end

    assign drv_en_o   = en_n;
    assign drv_data_o = dat_n;
endmodule

// File: rtl/sro_read_out.sv
`timescale 1ns/1ps
module sro_read_out
    import sro_pkg::*;
#(
    parameter int DW = 36
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pipe_sel_i,
    input  logic          dcd_sel_i,
    input  logic [1:0]    cmd_i,
    input  logic [DW-1:0] rd_data_i,
    input  logic          oe_n_i,
    input  logic          sleep_i,
    output logic [DW-1:0] dq_o,
    output logic          dq_oe_o
);
    mode_t         mode;
    cmd_e          cmd;
    evt_t          ev_early, ev_late_in, ev_late;
    logic [DW-1:0] late_data;
    logic          drv_en;
    logic [DW-1:0] drv_data;
    logic          mode_pipe, mode_dcd;

    assign cmd        = cmd_e'(cmd_i);
    assign mode_pipe  = mode.pipe;
    assign mode_dcd   = mode.dcd;
    assign ev_early   = early_evt(cmd, mode, sleep_i);
    assign ev_late_in = late_evt(cmd, mode, sleep_i);

    sro_mode_latch u_mode (
        .clk        (clk),
        .rst        (rst),
        .pipe_sel_i (pipe_sel_i),
        .dcd_sel_i  (dcd_sel_i),
        .mode_o     (mode)
    );

    sro_late_stage #(.DW(DW)) u_late (
        .clk    (clk),
        .rst    (rst),
        .evt_i  (ev_late_in),
        .data_i (rd_data_i),
        .evt_o  (ev_late),
        .data_o (late_data)
    );

    sro_resolver #(.DW(DW)) u_res (
        .clk          (clk),
        .rst          (rst),
        .sleep_i      (sleep_i),
        .early_i      (ev_early),
        .early_data_i (rd_data_i),
        .late_i       (ev_late),
        .late_data_i  (late_data),
        .drv_en_o     (drv_en),
        .drv_data_o   (drv_data)
    );

    // driver enable: asynchronous gating by output enable and sleep
    assign dq_oe_o = drv_en && !oe_n_i && !sleep_i && !rst;
    assign dq_o    = rst ? '0 : drv_data;
endmodule

// File: rtl/sro_read_out_chk.sv
`timescale 1ns/1ps
module sro_read_out_chk #(
    parameter int DW = 36
) (
    input logic          clk,
    input logic          rst,
    input logic [1:0]    cmd_i,
    input logic [DW-1:0] rd_data_i,
    input logic          oe_n_i,
    input logic          sleep_i,
    input logic [DW-1:0] dq_o,
    input logic          dq_oe_o,
    input logic          pipe_q,
    input logic          dcd_q
);
    // R1: bus floats in reset
    a_r1_reset_float: assert property (@(posedge clk) rst |-> !dq_oe_o);

    // R3: flow-through read drives its own data in its own cycle
    a_r3_ft_same_cycle: assert property (@(posedge clk) disable iff (rst)
        (!pipe_q && cmd_i == 2'b01 && !sleep_i && !oe_n_i)
        |-> (dq_oe_o && dq_o == rd_data_i));

    // R4, R7: pipelined read data appears next cycle unless a newer deselect floats it
    a_r4_pipe_next_cycle: assert property (@(posedge clk) disable iff (rst)
        (pipe_q && cmd_i == 2'b01 && !sleep_i)
        |=> (sleep_i || (cmd_i == 2'b10 && !dcd_q) || dq_o == $past(rd_data_i)));

    // R5: single-cycle deselect floats the bus at once
    a_r5_scd_float: assert property (@(posedge clk) disable iff (rst)
        (!dcd_q && cmd_i == 2'b10) |-> !dq_oe_o);

    // R6: dual-cycle deselect floats the bus next cycle unless a flow-through read overrides
    a_r6_dcd_float: assert property (@(posedge clk) disable iff (rst)
        (dcd_q && cmd_i == 2'b10 && !sleep_i)
        |=> (!dq_oe_o || (!pipe_q && cmd_i == 2'b01)));

    // R8: output enable high keeps drivers off
    a_r8_oe_gate: assert property (@(posedge clk) disable iff (rst)
        oe_n_i |-> !dq_oe_o);

    // R9: sleep keeps drivers off
    a_r9_sleep_float: assert property (@(posedge clk) disable iff (rst)
        sleep_i |-> !dq_oe_o);
endmodule

bind sro_read_out sro_read_out_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd_i     (cmd_i),
    .rd_data_i (rd_data_i),
    .oe_n_i    (oe_n_i),
    .sleep_i   (sleep_i),
    .dq_o      (dq_o),
    .dq_oe_o   (dq_oe_o),
    .pipe_q    (mode_pipe),
    .dcd_q     (mode_dcd)
);

// File: tb/sim_sro_read_out.sv
`timescale 1ns/1ps
module sim_sro_read_out;
    localparam int DW = 36;
    localparam int NV = 18;

    typedef struct packed {
        logic [1:0] cmd;
        logic       slp;
        logic       oen;
    } vec_t;

    // cmd: 01 read, 10 deselect, 00/11 no-op
    localparam vec_t VEC [NV] = '{
        '{2'b00, 1'b0, 1'b0},  // 0  R2 idle
        '{2'b01, 1'b0, 1'b0},  // 1  R3/R4 read
        '{2'b01, 1'b0, 1'b0},  // 2  back-to-back read
        '{2'b00, 1'b0, 1'b0},  // 3  R2 hold
        '{2'b10, 1'b0, 1'b0},  // 4  R5/R6 deselect
        '{2'b00, 1'b0, 1'b0},  // 5
        '{2'b01, 1'b0, 1'b0},  // 6  read
        '{2'b10, 1'b0, 1'b0},  // 7  R7 read then deselect
        '{2'b01, 1'b0, 1'b0},  // 8  R7 deselect then read
        '{2'b00, 1'b0, 1'b1},  // 9  R8 oe high
        '{2'b00, 1'b0, 1'b0},  // 10
        '{2'b01, 1'b1, 1'b0},  // 11 R9 read ignored asleep
        '{2'b10, 1'b1, 1'b0},  // 12 R9 deselect ignored asleep
        '{2'b00, 1'b0, 1'b0},  // 13 R9 wake, state restored
        '{2'b11, 1'b0, 1'b0},  // 14 R2 reserved code is no-op
        '{2'b10, 1'b0, 1'b0},  // 15 deselect
        '{2'b00, 1'b0, 1'b0},  // 16
        '{2'b00, 1'b0, 1'b0}   // 17
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          pipe_sel = 1'b0;
    logic          dcd_sel = 1'b0;
    logic [1:0]    cmd = 2'b00;
    logic [DW-1:0] rd_data = '0;
    logic          oe_n = 1'b0;
    logic          sleep = 1'b0;
    logic [DW-1:0] dq;
    logic          dq_oe;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // reference state
    logic          m_en, p_hit, p_on;
    logic [DW-1:0] m_dat, p_dat;

    always #5 clk = ~clk;

    sro_read_out #(.DW(DW)) u0 (
        .clk        (clk),
        .rst        (rst),
        .pipe_sel_i (pipe_sel),
        .dcd_sel_i  (dcd_sel),
        .cmd_i      (cmd),
        .rd_data_i  (rd_data),
        .oe_n_i     (oe_n),
        .sleep_i    (sleep),
        .dq_o       (dq),
        .dq_oe_o    (dq_oe)
    );

    function automatic logic [DW-1:0] pat(int i, int m);
        return DW'(i * 32'h0135_79BD + m * 32'h0001_1111 + 32'h5A);
    endfunction

    function automatic string tag_of(int i, logic [1:0] c, logic s, logic o);
        if (s) return "R9";
        if (o) return "R8";
        if (i == 7 || i == 8) return "R7";
        if (i == 13) return "R9";
        if (c == 2'b01) return pipe_sel ? "R4" : "R3";
        if (c == 2'b10) return dcd_sel ? "R6" : "R5";
        return "R2";
    endfunction

    task automatic check(string tag, logic [DW-1:0] ad, logic ae,
                         logic [DW-1:0] xd, logic xe);
        total++;
        if (ad !== xd || ae !== xe) begin
            bad++;
            $display("FAIL %s mode=%0d%0d actual oe=%0b dq=%h expected oe=%0b dq=%h",
                     tag, pipe_sel, dcd_sel, ae, ad, xe, xd);
        end
    endtask

    task automatic do_reset(logic p, logic d);
        rst = 1'b1; pipe_sel = p; dcd_sel = d;
        cmd = 2'b00; oe_n = 1'b0; sleep = 1'b0;
        repeat (3) @(posedge clk);
        #4;
        check("R1", dq, dq_oe, '0, 1'b0);    // R1 reset state
        @(posedge clk);
        #1 rst = 1'b0;
        m_en = 1'b0; m_dat = '0; p_hit = 1'b0; p_on = 1'b0; p_dat = '0;
    endtask

    task automatic run_table(int m);
        for (int i = 0; i < NV; i++) begin
            logic e0, en, nxt;
            logic [DW-1:0] dd, xd;
            @(posedge clk);
            #1;
            cmd = VEC[i].cmd; sleep = VEC[i].slp; oe_n = VEC[i].oen;
            dd = pat(i, m); rd_data = dd;
            #4;
            e0 = !sleep && ((cmd == 2'b01 && !pipe_sel) || (cmd == 2'b10 && !dcd_sel));
            en = m_en; xd = m_dat;
            if (e0) begin
                en = (cmd == 2'b01);
                if (en) xd = dd;
            end else if (p_hit && !sleep) begin
                en = p_on;
                if (p_on) xd = p_dat;
            end
            check(tag_of(i, cmd, sleep, oe_n), dq, dq_oe, xd, en && !oe_n && !sleep);
            if (!sleep) begin m_en = en; m_dat = xd; end
            nxt = !sleep && ((cmd == 2'b01 && pipe_sel) || (cmd == 2'b10 && dcd_sel));
            p_hit = nxt; p_on = (cmd == 2'b01); p_dat = dd;
        end
    endtask

    // R8: output enable acts between clock edges
    task automatic oe_async(int m);
        logic [DW-1:0] dd;
        @(posedge clk);
        #1 cmd = 2'b01; dd = pat(40, m); rd_data = dd;
        @(posedge clk);
        #1 cmd = 2'b00;
        @(posedge clk);
        #3;
        check("R8", dq, dq_oe, dd, 1'b1);
        oe_n = 1'b1;
        #1 check("R8", dq, dq_oe, dd, 1'b0);
        oe_n = 1'b0;
        #1 check("R8", dq, dq_oe, dd, 1'b1);
    endtask

    initial begin
        for (int m = 0; m < 4; m++) begin
            do_reset(m[1], m[0]);
            run_table(m);
            oe_async(m);
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule